// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Dedicated Request and Grant Lines

This block decides which of several bus masters may use a shared bus. Every master drives its own request line into the arbiter and receives its own grant line back. When more than one master asks at the same time, the master with the lowest index wins, so the priority order is fixed by wiring position. Internally the request vector is first reduced to the index of the winning requester plus a flag that says whether any request is present. A second stage then expands that index back into a one-hot grant.

A new grant is only issued while the shared bus is idle. The arbiter samples an external busy indication and also raises its own busy output for as long as any grant is held. A granted master keeps the bus until it lowers its request. A request from a higher-priority master that arrives in the meantime does not take the bus away. After a release the grant vector is empty for one cycle, and arbitration then starts again from the current requests.

Top module: `fixed_prio_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the grant vector is all zero and the busy output is low.
- R2: At most one grant bit is high in any cycle.
- R3: When no grant is held and several masters request at once, the grant goes to the requesting master with the lowest index. Bit i of the request and grant vectors belongs to master i.
- R4: While the external busy input is high and no grant is held, no grant is issued, whatever the requests.
- R5: The grant is registered. A request presented before a clock edge, while the bus is idle, produces the grant after that edge.
- R6: A master that holds a grant keeps it for as long as its own request stays high, even when a higher-priority request appears.
- R7: When the grant holder lowers its request, the grant vector is all zero after the next edge. A waiting master is granted one edge later.
- R8: The busy output is high exactly when some grant bit is high.
- R9: A newly issued grant always goes to a master whose request was high before the edge that issued it. With no requests, the grant stays all zero.
- R10: The external busy input has no effect on a grant that is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_MASTERS | One request line per master, bit i for master i |
| bus_busy_in | input | 1 | Shared bus busy indication from outside; blocks new grants |
| gnt | output | NUM_MASTERS | Registered one-hot grant, bit i for master i |
| bus_busy_out | output | 1 | High while any grant is held |

## Verification
The only state in this block is the registered grant vector. A corrupted value therefore shows at the grant and busy ports on the very cycle it is stored. A lost hold shows up as a grant moving to another master, or dropping, while the holder still requests. A wrong encoder index shows up one edge after an idle-bus request, as a grant bit that is not the lowest requesting index. A missed release shows up as a grant that stays set one edge after its request falls. A missed busy gate shows up as a grant that appears while the external busy input is high.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Width of an index able to address n masters (at least one bit).
  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/arb_prio_encoder.sv
module arb_prio_encoder #(
  parameter int NUM_MASTERS = 8,
  localparam int IDX_W = arb_pkg::idx_width(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  output logic [IDX_W-1:0]       win_idx,
  output logic                   win_valid
);

  // Scan from the top so the lowest requesting index is written last.
  always_comb begin
    win_idx = '0;
    for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
      if (req[i]) win_idx = IDX_W'(i);
    end
  end

  assign win_valid = |req;

  AST_ENC_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (req[win_idx] && ((req & ((NUM_MASTERS'(1) << win_idx) - NUM_MASTERS'(1))) == '0))); // R3

endmodule

// File: rtl/arb_grant_decoder.sv
module arb_grant_decoder #(
  parameter int NUM_MASTERS = 8,
  localparam int IDX_W = arb_pkg::idx_width(NUM_MASTERS)
) (
  input  logic [IDX_W-1:0]       sel_idx,
  input  logic                   sel_en,
  output logic [NUM_MASTERS-1:0] onehot
);

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_line
    assign onehot[g] = sel_en && (sel_idx == IDX_W'(g));
  end

  always_comb begin
    if (sel_en) AST_DEC_ONEHOT: assert ($onehot(onehot)); // R2
  end

endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl #(
  parameter int NUM_MASTERS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   bus_busy_in,
  input  logic                   win_valid,
  input  logic [NUM_MASTERS-1:0] dec_onehot,
  output logic                   launch,
  output logic [NUM_MASTERS-1:0] gnt_q
);

  logic                   holder_active;
  logic                   idle;
  logic [NUM_MASTERS-1:0] gnt_d;
  logic                   gnt_en;

  // Next-state logic
  always_comb begin
    holder_active = |(gnt_q & req);
    idle          = (gnt_q == '0);
    launch        = idle && !bus_busy_in && win_valid;
    if (holder_active)  gnt_d = gnt_q;
    else if (launch)    gnt_d = dec_onehot;
    else                gnt_d = '0;
    gnt_en = (gnt_d != gnt_q);
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= '0;
    else if (gnt_en) gnt_q <= gnt_d;
  end

  AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q)); // R2
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q & req) != '0) |=> (gnt_q == $past(gnt_q))); // R6
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q != '0) && ((gnt_q & req) == '0)) |=> (gnt_q == '0)); // R7
  AST_NO_GNT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q == '0) && bus_busy_in) |=> (gnt_q == '0)); // R4
  AST_NEW_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q == '0) && (req == '0)) |=> (gnt_q == '0)); // R9

endmodule

// File: rtl/fixed_prio_arbiter.sv
module fixed_prio_arbiter #(
  parameter int NUM_MASTERS = 8,
  localparam int IDX_W = arb_pkg::idx_width(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   bus_busy_in,
  output logic [NUM_MASTERS-1:0] gnt,
  output logic                   bus_busy_out
);

  logic [IDX_W-1:0]       win_idx;
  logic                   win_valid;
  logic                   launch;
  logic [NUM_MASTERS-1:0] dec_onehot;
  logic [NUM_MASTERS-1:0] gnt_q;

  arb_prio_encoder #(.NUM_MASTERS(NUM_MASTERS)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .win_idx   (win_idx),
    .win_valid (win_valid)
  );

  arb_grant_decoder #(.NUM_MASTERS(NUM_MASTERS)) u_dec (
    .sel_idx (win_idx),
    .sel_en  (launch),
    .onehot  (dec_onehot)
  );

  arb_grant_ctrl #(.NUM_MASTERS(NUM_MASTERS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .bus_busy_in (bus_busy_in),
    .win_valid   (win_valid),
    .dec_onehot  (dec_onehot),
    .launch      (launch),
    .gnt_q       (gnt_q)
  );

  assign gnt          = gnt_q;
  assign bus_busy_out = |gnt_q;

  AST_BUSY_ROSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy_out) |-> $past(!bus_busy_in)); // R4
  AST_BUSY_FALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy_out) |-> (($past(gnt) & $past(req)) == '0)); // R8
  AST_HOLD_IGNORES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy_out && ((gnt & req) != '0) && bus_busy_in) |=> $stable(gnt)); // R10

endmodule

// File: tb/tb_fixed_prio_arbiter.sv
module tb_fixed_prio_arbiter;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         bus_busy_in;
  logic [N-1:0] gnt;
  logic         bus_busy_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fixed_prio_arbiter #(.NUM_MASTERS(N)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .bus_busy_in  (bus_busy_in),
    .gnt          (gnt),
    .bus_busy_out (bus_busy_out)
  );

  // Inputs change and outputs are sampled 1 ns after a rising edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_gnt(input string tag, input logic [N-1:0] exp);
    n_checks++;
    if (gnt !== exp) begin
      n_fails++;
      $display("FAIL %s: gnt actual=%b expected=%b", tag, gnt, exp);
    end
    n_checks++;
    if (bus_busy_out !== (exp != '0)) begin
      n_fails++;
      $display("FAIL R8 (%s): bus_busy_out actual=%b expected=%b", tag, bus_busy_out, exp != '0);
    end
  endtask

  task automatic settle();
    req = '0;
    bus_busy_in = 1'b0;
    tick();
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req = 8'hFF;
    bus_busy_in = 1'b0;
    #3;
    chk_gnt("R1 during reset", '0);
    tick();
    chk_gnt("R1 held in reset", '0);
    req = '0;
    rst_n = 1'b1;
    tick();
    chk_gnt("R1 after release", '0);
  endtask

  task automatic t_single();
    req = 8'b0001_0000;
    tick();
    chk_gnt("R5 single grant", 8'b0001_0000);
    req = '0;
    tick();
    chk_gnt("R7 single release", '0);
    settle();
  endtask

  task automatic t_priority();
    req = 8'b1010_1100;
    tick();
    chk_gnt("R3 lowest index wins", 8'b0000_0100);
    req = 8'b1010_1000;
    tick();
    chk_gnt("R7 empty cycle after release", '0);
    tick();
    chk_gnt("R3 next lowest wins", 8'b0000_1000);
    req = 8'b1010_0000;
    tick();
    chk_gnt("R7 second release", '0);
    tick();
    chk_gnt("R3 third winner", 8'b0010_0000);
    settle();
  endtask

  task automatic t_busy_block();
    req = 8'b0000_0001;
    bus_busy_in = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_gnt("R4 busy blocks grant", '0);
    end
    bus_busy_in = 1'b0;
    tick();
    chk_gnt("R4 grant after busy clears", 8'b0000_0001);
    settle();
  endtask

  task automatic t_hold();
    req = 8'b1000_0000;
    tick();
    chk_gnt("R5 lowest priority granted", 8'b1000_0000);
    req = 8'b1000_0001;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_gnt("R6 hold against higher priority", 8'b1000_0000);
    end
    bus_busy_in = 1'b1;
    tick();
    chk_gnt("R10 busy ignored while held", 8'b1000_0000);
    bus_busy_in = 1'b0;
    req = 8'b0000_0001;
    tick();
    chk_gnt("R7 holder released", '0);
    tick();
    chk_gnt("R9 waiting requester granted", 8'b0000_0001);
    settle();
  endtask

  task automatic t_no_request();
    req = '0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_gnt("R9 no request no grant", '0);
    end
    req = 8'b0100_0000;
    tick();
    chk_gnt("R9 grant to requester only", 8'b0100_0000);
    settle();
  endtask

  initial begin
    rst_n = 1'b0;
    req = '0;
    bus_busy_in = 1'b0;
    t_reset();
    t_single();
    t_priority();
    t_busy_block();
    t_hold();
    t_no_request();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule